// File: doc/BRIEF.md
# Constant-Building Instruction Fusion Pre-Decoder

This block sits ahead of full decode in a 64-bit core that fetches 32-bit fixed-length instructions. Each cycle it looks at a two-instruction window. It recognises two common constant-building idioms and turns each of them into a single internal micro-op. The first idiom is an upper-immediate load followed by an immediate add on the same register, which becomes one 32-bit constant load. The second is a pair of shift-left-16-and-OR-immediate instructions on the same register, which becomes one shift-left-32-and-OR of a 32-bit immediate. With both fusions, a full 64-bit constant costs two issue slots instead of four.

The block emits one micro-op per cycle, one cycle after the window is presented. It also reports how many window instructions that micro-op used up: two when a fusion took place, one when the first instruction went through alone, and zero when the window was empty. The fetch side advances the window by that count. Instructions that are not fused come out as pass-through micro-ops that carry the raw word for the full decoder.

Top module: `fuse_decoder`

## Requirements
- R1: While reset is asserted and after it is released with no input, `uop_valid` is 0 and `uop_consumed` is 0.
- R2: Slot 0 holds an upper-immediate load (opcode bits [6:0] = 7'b0110111, rd in [11:7], 20-bit immediate in [31:12]). Slot 1 holds an add-immediate (opcode 7'b0010011, funct3 [14:12] = 3'b000, rd [11:7], rs1 [19:15], 12-bit immediate [31:20]). When both slots are valid, the add's rd and rs1 both equal the load's rd, and immediate bit [31] of the add is 0, the next cycle shows one micro-op. That micro-op has kind 1 (32-bit constant load), rd set to that register, `uop_imm` equal to the architectural result of the two instructions, and consumed count 2.
- R3: If the add-immediate's bit [31] is 1, no fusion occurs. The micro-op is a pass-through (kind 0) of slot 0, with consumed count 1.
- R4: If the add's rd or its rs1 differs from the load's rd, no fusion occurs (pass-through of slot 0, consumed 1).
- R5: Two valid shift-OR instructions (opcode 7'b0001011, rd [11:7], 16-bit immediate [31:16]) that name the same rd fuse into kind 2. Its `uop_imm` is the zero-extended value {slot-0 immediate, slot-1 immediate}, and the consumed count is 2.
- R6: Two shift-OR instructions with different rd do not fuse (pass-through of slot 0, consumed 1).
- R7: A destination of register 0 prevents either fusion. The pass-through micro-op is emitted with consumed 1.
- R8: A pass-through micro-op has kind 0, rd from slot 0 bits [11:7], `uop_imm` 0 and `uop_raw` equal to slot 0. It is produced whenever slot 0 is valid and no fusion applies, including when slot 1 is invalid.
- R9: When slot 0 is not valid, the next cycle has `uop_valid` 0 and consumed count 0, whatever slot 1 holds.
- R10: A fused 32-bit constant with bit 31 set is sign-extended into bits [63:32].
- R11: The sequence load-upper, add, shift-OR, shift-OR on one register, presented as two successive windows, produces exactly two fused micro-ops on two consecutive cycles.
- R12: An add-immediate followed by an upper-immediate load (reverse order) does not fuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_insn0 | input | 32 | Window slot 0 (older instruction) |
| in_vld0 | input | 1 | Slot 0 holds an instruction |
| in_insn1 | input | 32 | Window slot 1 (younger instruction) |
| in_vld1 | input | 1 | Slot 1 holds an instruction |
| uop_valid | output | 1 | A micro-op is present |
| uop_kind | output | 2 | 0 pass-through, 1 32-bit constant load, 2 shift-32-OR |
| uop_rd | output | 5 | Destination register |
| uop_imm | output | 64 | Expanded immediate (0 for pass-through) |
| uop_raw | output | 32 | Slot 0 word, for full decode of pass-through |
| uop_consumed | output | 2 | Window instructions used up (0, 1 or 2) |

## Verification
The bench targets the gates on each fusion: a negative add immediate, a mismatched rd or rs1, register 0 as the destination, an invalid second slot, and the reverse order. A design that ignored any one of these would report a fused kind with consumed 2 and swallow an instruction that still needs issuing. It also checks a constant with bit 31 set. A design that zero-extended that constant would leave the upper word clear instead of all ones. The shift-OR pair is checked for immediate order, since swapped halves would give the wrong 32-bit value. The full four-instruction sequence must give two fused micro-ops on consecutive cycles.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int ILEN = 32;
  localparam int XLEN = 64;
  localparam int RLEN = 5;

  localparam logic [6:0] OPC_UPPER = 7'b0110111;
  localparam logic [6:0] OPC_ADDI  = 7'b0010011;
  localparam logic [6:0] OPC_SHOR  = 7'b0001011;

  typedef enum logic [1:0] {
    UOP_PASS   = 2'd0,
    UOP_LI32   = 2'd1,
    UOP_SHOR32 = 2'd2
  } uop_kind_e;
endpackage

// File: rtl/fuse_match.sv
module fuse_match
  import fuse_pkg::*;
#(
  parameter int IW = ILEN,
  parameter int RW = RLEN
) (
  input  logic [IW-1:0] insn0,
  input  logic [IW-1:0] insn1,
  input  logic          vld1,
  output logic          li_pair,
  output logic          shor_pair
);
  logic [RW-1:0] rd0, rd1, rs1_1;
  logic          upper0, addi1, shor0, shor1, rd0_nz;

  always_comb begin
    rd0    = insn0[7 +: RW];
    rd1    = insn1[7 +: RW];
    rs1_1  = insn1[15 +: RW];
    rd0_nz = |rd0;
    upper0 = insn0[6:0] == OPC_UPPER;
    addi1  = (insn1[6:0] == OPC_ADDI) && (insn1[14:12] == 3'b000);
    shor0  = insn0[6:0] == OPC_SHOR;
    shor1  = insn1[6:0] == OPC_SHOR;

    li_pair   = vld1 && rd0_nz && upper0 && addi1 &&
                (rd1 == rd0) && (rs1_1 == rd0) && !insn1[IW-1];
    shor_pair = vld1 && rd0_nz && shor0 && shor1 && (rd1 == rd0);
  end
endmodule

// File: rtl/fuse_imm.sv
module fuse_imm
  import fuse_pkg::*;
#(
  parameter int IW = ILEN,
  parameter int XW = XLEN
) (
  input  logic [IW-1:0] insn0,
  input  logic [IW-1:0] insn1,
  input  uop_kind_e     kind,
  output logic [XW-1:0] imm
);
  localparam int HW = XW - 32;
  logic [31:0] li_lo;
  logic [31:0] sh_lo;

  always_comb begin
    li_lo = {insn0[31:12], insn1[31:20]};
    sh_lo = {insn0[31:16], insn1[31:16]};
    unique case (kind)
      UOP_LI32:   imm = {{HW{li_lo[31]}}, li_lo};
      UOP_SHOR32: imm = {{HW{1'b0}}, sh_lo};
      default:    imm = '0;
    endcase
  end
endmodule

// File: rtl/fuse_decoder.sv
module fuse_decoder
  import fuse_pkg::*;
#(
  parameter int IW = ILEN,
  parameter int XW = XLEN,
  parameter int RW = RLEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] in_insn0,
  input  logic          in_vld0,
  input  logic [IW-1:0] in_insn1,
  input  logic          in_vld1,
  output logic          uop_valid,
  output logic [1:0]    uop_kind,
  output logic [RW-1:0] uop_rd,
  output logic [XW-1:0] uop_imm,
  output logic [IW-1:0] uop_raw,
  output logic [1:0]    uop_consumed
);
  logic          li_pair, shor_pair;
  uop_kind_e     kind_nxt;
  logic [XW-1:0] imm_nxt;
  logic [1:0]    cons_nxt;
  logic          data_en;

  logic          valid_q;
  uop_kind_e     kind_q;
  logic [RW-1:0] rd_q;
  logic [XW-1:0] imm_q;
  logic [IW-1:0] raw_q;
  logic [1:0]    cons_q;

  fuse_match #(.IW(IW), .RW(RW)) i_match (
    .insn0     (in_insn0),
    .insn1     (in_insn1),
    .vld1      (in_vld1),
    .li_pair   (li_pair),
    .shor_pair (shor_pair)
  );

  fuse_imm #(.IW(IW), .XW(XW)) i_imm (
    .insn0 (in_insn0),
    .insn1 (in_insn1),
    .kind  (kind_nxt),
    .imm   (imm_nxt)
  );

  always_comb begin
    data_en = in_vld0;
    if (li_pair)        kind_nxt = UOP_LI32;
    else if (shor_pair) kind_nxt = UOP_SHOR32;
    else                kind_nxt = UOP_PASS;
    if (!in_vld0)              cons_nxt = 2'd0;
    else if (kind_nxt != UOP_PASS) cons_nxt = 2'd2;
    else                       cons_nxt = 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cons_q  <= 2'd0;
    end else begin
      valid_q <= in_vld0;
      cons_q  <= cons_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= UOP_PASS;
      rd_q   <= '0;
      imm_q  <= '0;
      raw_q  <= '0;
    end else if (data_en) begin
      kind_q <= kind_nxt;
      rd_q   <= in_insn0[7 +: RW];
      imm_q  <= imm_nxt;
      raw_q  <= in_insn0;
    end
  end

  assign uop_valid    = valid_q;
  assign uop_kind     = kind_q;
  assign uop_rd       = rd_q;
  assign uop_imm      = imm_q;
  assign uop_raw      = raw_q;
  assign uop_consumed = cons_q;
endmodule

// File: rtl/fuse_checker.sv
module fuse_checker
  import fuse_pkg::*;
#(
  parameter int IW = ILEN,
  parameter int XW = XLEN,
  parameter int RW = RLEN
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] in_insn0,
  input logic          in_vld0,
  input logic [IW-1:0] in_insn1,
  input logic          in_vld1,
  input logic          uop_valid,
  input logic [1:0]    uop_kind,
  input logic [RW-1:0] uop_rd,
  input logic [XW-1:0] uop_imm,
  input logic [1:0]    uop_consumed
);
  p_fused_takes_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_kind != UOP_PASS) |-> uop_consumed == 2'd2);

  p_neg_add_unfused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld0 && in_vld1 && in_insn0[6:0] == OPC_UPPER && in_insn1[IW-1])
    |=> (uop_kind == UOP_PASS && uop_consumed == 2'd1));

  p_shor_upper_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_kind == UOP_SHOR32) |-> uop_imm[XW-1:32] == '0);

  p_no_x0_fusion_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_kind != UOP_PASS) |-> uop_rd != '0);

  p_lone_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld0 && !in_vld1)
    |=> (uop_valid && uop_kind == UOP_PASS && uop_consumed == 2'd1));

  p_empty_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld0 |=> (!uop_valid && uop_consumed == 2'd0));

  p_const_sext_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_kind == UOP_LI32) |-> uop_imm[XW-1:32] == {(XW-32){uop_imm[31]}});
endmodule

bind fuse_decoder fuse_checker #(.IW(IW), .XW(XW), .RW(RW)) i_fuse_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_insn0     (in_insn0),
  .in_vld0      (in_vld0),
  .in_insn1     (in_insn1),
  .in_vld1      (in_vld1),
  .uop_valid    (uop_valid),
  .uop_kind     (uop_kind),
  .uop_rd       (uop_rd),
  .uop_imm      (uop_imm),
  .uop_consumed (uop_consumed)
);

// File: tb/test_fuse_decoder.sv
module test_fuse_decoder;
  logic        clk;
  logic        rst_n;
  logic [31:0] in_insn0, in_insn1;
  logic        in_vld0, in_vld1;
  logic        uop_valid;
  logic [1:0]  uop_kind;
  logic [4:0]  uop_rd;
  logic [63:0] uop_imm;
  logic [31:0] uop_raw;
  logic [1:0]  uop_consumed;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        valid;
    logic [1:0]  kind;
    logic [4:0]  rd;
    logic [63:0] imm;
    logic [31:0] raw;
    logic [1:0]  cons;
    string       req;
  } exp_t;

  exp_t sb[$];

  fuse_decoder i_fuse_decoder (
    .clk(clk), .rst_n(rst_n),
    .in_insn0(in_insn0), .in_vld0(in_vld0),
    .in_insn1(in_insn1), .in_vld1(in_vld1),
    .uop_valid(uop_valid), .uop_kind(uop_kind), .uop_rd(uop_rd),
    .uop_imm(uop_imm), .uop_raw(uop_raw), .uop_consumed(uop_consumed)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] enc_upper(input logic [4:0] rd, input logic [19:0] imm);
    return {imm, rd, 7'b0110111};
  endfunction
  function automatic logic [31:0] enc_addi(input logic [4:0] rd, input logic [4:0] rs,
                                          input logic [11:0] imm);
    return {imm, rs, 3'b000, rd, 7'b0010011};
  endfunction
  function automatic logic [31:0] enc_shor(input logic [4:0] rd, input logic [15:0] imm);
    return {imm, 4'b0000, rd, 7'b0001011};
  endfunction
  // architectural result of load-upper then add-immediate on a 64-bit machine
  function automatic logic [63:0] arch_li(input logic [19:0] hi, input logic [11:0] lo);
    logic [63:0] a, b;
    a = {{32{hi[19]}}, hi, 12'h000};
    b = {{52{lo[11]}}, lo};
    return a + b;
  endfunction

  task automatic drive(input logic v0, input logic [31:0] w0, input logic v1,
                       input logic [31:0] w1, input exp_t e);
    @(negedge clk);
    in_vld0 = v0; in_insn0 = w0; in_vld1 = v1; in_insn1 = w1;
    sb.push_back(e);
  endtask

  function automatic exp_t e_pass(input logic [31:0] w, input string req);
    exp_t e;
    e.valid = 1'b1; e.kind = 2'd0; e.rd = w[11:7]; e.imm = '0; e.raw = w;
    e.cons = 2'd1; e.req = req;
    return e;
  endfunction
  function automatic exp_t e_fused(input logic [1:0] k, input logic [4:0] rd,
                                   input logic [63:0] imm, input logic [31:0] w,
                                   input string req);
    exp_t e;
    e.valid = 1'b1; e.kind = k; e.rd = rd; e.imm = imm; e.raw = w;
    e.cons = 2'd2; e.req = req;
    return e;
  endfunction
  function automatic exp_t e_idle(input string req);
    exp_t e;
    e.valid = 1'b0; e.kind = 2'd0; e.rd = '0; e.imm = '0; e.raw = '0;
    e.cons = 2'd0; e.req = req;
    return e;
  endfunction

  // monitor: pops one expected item per cycle, after the output register updates
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      logic bad;
      e = sb.pop_front();
      checks++;
      if (e.valid)
        bad = (uop_valid !== 1'b1) || (uop_kind !== e.kind) || (uop_rd !== e.rd) ||
              (uop_imm !== e.imm) || (uop_raw !== e.raw) || (uop_consumed !== e.cons);
      else
        bad = (uop_valid !== 1'b0) || (uop_consumed !== 2'd0);
      if (bad) begin
        errors++;
        $display("FAIL %s: got v=%0b k=%0d rd=%0d imm=%h raw=%h c=%0d exp v=%0b k=%0d rd=%0d imm=%h raw=%h c=%0d",
                 e.req, uop_valid, uop_kind, uop_rd, uop_imm, uop_raw, uop_consumed,
                 e.valid, e.kind, e.rd, e.imm, e.raw, e.cons);
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w0, w1;
    rst_n = 1'b0; in_vld0 = 1'b0; in_vld1 = 1'b0; in_insn0 = '0; in_insn1 = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (uop_valid !== 1'b0 || uop_consumed !== 2'd0) begin
      errors++;
      $display("FAIL R1: got v=%0b c=%0d exp v=0 c=0", uop_valid, uop_consumed);
    end
    @(negedge clk); rst_n = 1'b1;
    drive(0, '0, 0, '0, e_idle("R1"));

    // R2: plain fusion
    w0 = enc_upper(5'd5, 20'h12345); w1 = enc_addi(5'd5, 5'd5, 12'h678);
    drive(1, w0, 1, w1, e_fused(2'd1, 5'd5, arch_li(20'h12345, 12'h678), w0, "R2"));
    // R10: bit 31 set, sign-extended
    w0 = enc_upper(5'd6, 20'h80001); w1 = enc_addi(5'd6, 5'd6, 12'h7ff);
    drive(1, w0, 1, w1, e_fused(2'd1, 5'd6, arch_li(20'h80001, 12'h7ff), w0, "R10"));
    // R3: negative add immediate
    w0 = enc_upper(5'd7, 20'h00042); w1 = enc_addi(5'd7, 5'd7, 12'h800);
    drive(1, w0, 1, w1, e_pass(w0, "R3"));
    // R4: rd mismatch, then rs1 mismatch
    w1 = enc_addi(5'd8, 5'd7, 12'h001);
    drive(1, w0, 1, w1, e_pass(w0, "R4"));
    w1 = enc_addi(5'd7, 5'd9, 12'h001);
    drive(1, w0, 1, w1, e_pass(w0, "R4"));
    // R5: shift-OR pair, slot 0 immediate on top
    w0 = enc_shor(5'd9, 16'hdead); w1 = enc_shor(5'd9, 16'hbeef);
    drive(1, w0, 1, w1, e_fused(2'd2, 5'd9, 64'h00000000_deadbeef, w0, "R5"));
    // R6: different rd
    w1 = enc_shor(5'd10, 16'hbeef);
    drive(1, w0, 1, w1, e_pass(w0, "R6"));
    // R7: x0 destination, both patterns
    w0 = enc_upper(5'd0, 20'h00123); w1 = enc_addi(5'd0, 5'd0, 12'h004);
    drive(1, w0, 1, w1, e_pass(w0, "R7"));
    w0 = enc_shor(5'd0, 16'h1234); w1 = enc_shor(5'd0, 16'h5678);
    drive(1, w0, 1, w1, e_pass(w0, "R7"));
    // R8: fusable pair but slot 1 not valid
    w0 = enc_upper(5'd12, 20'h00abc); w1 = enc_addi(5'd12, 5'd12, 12'h010);
    drive(1, w0, 0, w1, e_pass(w0, "R8"));
    // R9: slot 0 invalid with fusable data
    drive(0, w0, 1, w1, e_idle("R9"));
    // R12: reverse order
    drive(1, w1, 1, w0, e_pass(w1, "R12"));
    // R11: four-instruction sequence as two windows
    w0 = enc_upper(5'd11, 20'habcde); w1 = enc_addi(5'd11, 5'd11, 12'h123);
    drive(1, w0, 1, w1, e_fused(2'd1, 5'd11, arch_li(20'habcde, 12'h123), w0, "R11"));
    w0 = enc_shor(5'd11, 16'h1111); w1 = enc_shor(5'd11, 16'h2222);
    drive(1, w0, 1, w1, e_fused(2'd2, 5'd11, 64'h00000000_11112222, w0, "R11"));
    drive(0, '0, 0, '0, e_idle("R9"));

    repeat (3) @(posedge clk);
    #3;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending exp 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule